// File: doc/BRIEF.md
# Modulo path-history neural branch predictor

This block predicts the direction of conditional branches with a perceptron-style dot product. The history vector starts with a constant +1 for the bias term. Each of the `HIST` global outcome bits counts as +1 when the branch was taken and -1 when it was not. The weight for history position i does not come from the current branch address. It comes from the address of the (i mod `PATH`)-th most recent branch, where 0 means the current branch. The path history is therefore only `PATH` addresses long, while the outcome history is `HIST` bits. Every `PATH`-th weight shares one address, so the weights are interleaved across only `PATH` tables. A row of table t holds the `HIST/PATH` weights for positions t, t+`PATH`, t+2·`PATH` and so on. Table 0 also holds the bias weight, which the current address selects.

The lookup is pipelined across branches, so the pipeline is `PATH` stages deep rather than `HIST`. Each strobe presents the branch address and its resolved outcome. At that strobe, table k is read at the current row and adds its terms to the partial sum for the branch k strobes later. The final stage adds the bias and the table-0 weights of the current branch to the partial sum that has arrived, and drives the sum and the prediction combinationally. Training then adjusts every weight the current branch used, including the rows selected by older addresses. All reads return the state from before the clock edge, so a lookup and an update can share a cycle. Weight storage is internal register arrays with one read path and one write path per table.

Top module: `mph_predictor`

## Requirements
- R1: After reset, every weight and partial sum is zero and every history bit reads as not-taken. The first lookup therefore gives sum 0 and a taken prediction.
- R2: `pred_taken` is 1 exactly when the two's-complement `pred_sum` is zero or positive.
- R3: `pred_sum` is the bias weight plus the sum over positions i=1..`HIST` of +w_i or -w_i. The + sign applies when history bit i is taken. History bit i is the outcome of the i-th previous strobed branch, shifted in on each `br_valid` from `br_taken`.
- R4: w_i is taken from table (i mod `PATH`), at the row given by the low `IDXW` bits of the address of the (i mod `PATH`)-th most recent branch (0 = current). The bias weight uses the current row. Addresses that differ only above bit `IDXW-1` alias to the same row.
- R5: A term from an older address uses the weight value present when that older branch was strobed. Training between that strobe and the final stage does not change that term.
- R6: Training happens on a strobe with `train_en`=1 when the prediction differs from `br_taken`, or when |`pred_sum`| ≤ 37, which is floor(1.93·`HIST`+14).
- R7: Training moves each used weight by +1 when its history input (+1 for the bias) agrees with the outcome, and by -1 otherwise. It saturates at +127 and -128.
- R8: A cycle without `br_valid` changes no history, no partial sum and no weight.
- R9: A strobe with `train_en`=0 changes no weight, but it still shifts the history and advances the partial sums.
- R10: When a lookup and a training write hit the same row of a table in one cycle, the lookup uses the value from before the write.
- R11: `pred_sum` always lies within ±(`HIST`+1)·128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A conditional branch is presented this cycle |
| br_pc | input | PCW | Branch address |
| br_taken | input | 1 | Resolved direction of the presented branch |
| train_en | input | 1 | Allows weight training on this strobe |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_sum | output | SW | Signed full dot-product sum |

## Verification
The bench drives back-to-back strobes on one address, and cycles through addresses that alias onto one row. In that case a training write and a lookup land on the same row of the same table in the same cycle. A design that forwarded the freshly written weight, or that re-read older rows at the final stage instead of carrying partial sums, would drift from the reference sum within a few branches. Idle cycles with changing address and outcome, and strobes with training disabled, catch a design that shifts history or writes weights when it should not. A long correlated random phase pushes sums across the ±37 confidence band and the zero crossing. That exposes an off-by-one threshold, a strict-versus-inclusive sign test, a misplaced history tap or a table indexed by the wrong past address.

// File: rtl/mph_predictor.sv
module mph_predictor #(
  parameter int HIST = 12,
  parameter int PATH = 3,
  parameter int WW   = 8,
  parameter int IDXW = 6,
  parameter int PCW  = 32,
  parameter int SW   = WW + $clog2(HIST + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 br_valid,
  input  logic [PCW-1:0]       br_pc,
  input  logic                 br_taken,
  input  logic                 train_en,
  output logic                 pred_taken,
  output logic signed [SW-1:0] pred_sum
);
  localparam int ROWS  = 1 << IDXW;
  localparam int NPT   = HIST / PATH;
  localparam int THETA = (193 * HIST) / 100 + 14;
  localparam logic signed [SW-1:0] THR  = SW'(THETA);
  localparam logic signed [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic signed [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};

  logic signed [WW-1:0] wt [PATH][ROWS][NPT];
  logic signed [WW-1:0] bw [ROWS];
  logic [HIST-1:0]      hist;
  logic signed [SW-1:0] ps [PATH];
  logic [IDXW-1:0]      prow [PATH-1];
  logic signed [SW-1:0] contrib [PATH-1];
  logic signed [SW-1:0] acc;
  logic [HIST:0]        hx;
  logic [IDXW-1:0]      idx;
  logic                 do_train;
  logic                 pc_hi_unused;

  function automatic logic signed [SW-1:0] term(input logic pos, input logic signed [WW-1:0] w);
    logic signed [SW-1:0] e;
    e = {{(SW-WW){w[WW-1]}}, w};
    return pos ? e : -e;
  endfunction

  function automatic logic signed [WW-1:0] step(input logic signed [WW-1:0] w, input logic agree);
    if (agree) return (w == WMAX) ? w : w + 1'b1;
    return (w == WMIN) ? w : w - 1'b1;
  endfunction

  assign idx          = br_pc[IDXW-1:0];
  assign pc_hi_unused = ^br_pc[PCW-1:IDXW];
  assign hx           = {hist, br_taken};

  always_comb begin
    acc = ps[0] + term(1'b1, bw[idx]);
    for (int j = 0; j < NPT; j++)
      acc = acc + term(hx[(j+1)*PATH], wt[0][idx][j]);
    for (int m = 0; m < PATH-1; m++) begin
      contrib[m] = '0;
      for (int j = 0; j < NPT; j++)
        contrib[m] = contrib[m] + term(hx[j*PATH], wt[m+1][idx][j]);
    end
  end

  assign pred_sum   = acc;
  assign pred_taken = ~acc[SW-1];
  assign do_train   = br_valid && train_en &&
                      ((pred_taken != br_taken) || ((acc <= THR) && (acc >= -THR)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      for (int m = 0; m < PATH; m++) ps[m] <= '0;
      for (int m = 0; m < PATH-1; m++) prow[m] <= '0;
      for (int r = 0; r < ROWS; r++) begin
        bw[r] <= '0;
        for (int t = 0; t < PATH; t++)
          for (int j = 0; j < NPT; j++) wt[t][r][j] <= '0;
      end
    end else if (br_valid) begin
      hist <= hx[HIST-1:0];
      for (int m = 0; m < PATH-1; m++) ps[m] <= ps[m+1] + contrib[m];
      prow[0] <= idx;
      for (int m = 1; m < PATH-1; m++) prow[m] <= prow[m-1];
      if (do_train) begin
        bw[idx] <= step(bw[idx], br_taken);
        for (int j = 0; j < NPT; j++)
          wt[0][idx][j] <= step(wt[0][idx][j], hx[(j+1)*PATH] == br_taken);
        for (int m = 0; m < PATH-1; m++)
          for (int j = 0; j < NPT; j++)
            wt[m+1][prow[m]][j] <= step(wt[m+1][prow[m]][j], hx[m+1+j*PATH] == br_taken);
      end
    end
  end
endmodule

// File: rtl/mph_predictor_chk.sv
module mph_predictor_chk #(
  parameter int HIST = 12,
  parameter int WW   = 8,
  parameter int SW   = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 br_valid,
  input logic                 br_taken,
  input logic                 pred_taken,
  input logic signed [SW-1:0] pred_sum,
  input logic [HIST-1:0]      hist
);
  localparam logic signed [SW-1:0] BOUND = SW'((HIST + 1) * (1 << (WW-1)));
  logic seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else if (br_valid) seen <= 1'b1;
  end

  a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && br_valid) |-> (pred_sum == '0 && pred_taken));

  a_r3_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> hist == {$past(hist[HIST-2:0]), $past(br_taken)});

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(hist));

  a_r11_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_sum <= BOUND) && (pred_sum >= -BOUND));
endmodule

bind mph_predictor mph_predictor_chk #(.HIST(HIST), .WW(WW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
  .pred_taken(pred_taken), .pred_sum(pred_sum), .hist(hist)
);

// File: tb/mph_predictor_tb.sv
module mph_predictor_tb;
  localparam int HIST = 12, PATH = 3, WW = 8, IDXW = 6, PCW = 32;
  localparam int SW = WW + $clog2(HIST + 2);
  localparam int ROWS = 1 << IDXW, NPT = HIST / PATH, THETA = 37;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, br_valid, br_taken, train_en, pred_taken;
  logic [PCW-1:0] br_pc;
  logic signed [SW-1:0] pred_sum;

  mph_predictor #(.HIST(HIST), .PATH(PATH), .WW(WW), .IDXW(IDXW), .PCW(PCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc), .br_taken(br_taken),
    .train_en(train_en), .pred_taken(pred_taken), .pred_sum(pred_sum));

  int mw [PATH][ROWS][NPT];
  int mb [ROWS];
  int mh [HIST];
  int rrow [PATH];
  int rsnap [PATH][PATH][NPT];
  int total = 0, bad = 0;

  function automatic int sg(int b, int w);
    return (b != 0) ? w : -w;
  endfunction

  function automatic int sat(int w, bit agree);
    if (agree) return (w >= 127) ? w : w + 1;
    return (w <= -128) ? w : w - 1;
  endfunction

  function automatic int expect_sum(int r);
    int y = mb[r];
    for (int j = 0; j < NPT; j++) y += sg(mh[(j+1)*PATH-1], mw[0][r][j]);
    for (int k = 1; k < PATH; k++)
      for (int j = 0; j < NPT; j++) y += sg(mh[k+j*PATH-1], rsnap[k-1][k][j]);
    return y;
  endfunction

  task automatic commit(int r, int o, int te);
    int y, snap[PATH][NPT];
    bit mis;
    y = expect_sum(r);
    mis = ((y >= 0) ? 1 : 0) != o;
    for (int k = 0; k < PATH; k++)
      for (int j = 0; j < NPT; j++) snap[k][j] = mw[k][r][j];
    if (te != 0 && (mis || (y <= THETA && y >= -THETA))) begin
      mb[r] = sat(mb[r], o == 1);
      for (int j = 0; j < NPT; j++)
        mw[0][r][j] = sat(mw[0][r][j], mh[(j+1)*PATH-1] == o);
      for (int k = 1; k < PATH; k++)
        for (int j = 0; j < NPT; j++)
          mw[k][rrow[k-1]][j] = sat(mw[k][rrow[k-1]][j], mh[k+j*PATH-1] == o);
    end
    for (int m = PATH-1; m > 0; m--) begin
      rrow[m] = rrow[m-1];
      for (int k = 0; k < PATH; k++)
        for (int j = 0; j < NPT; j++) rsnap[m][k][j] = rsnap[m-1][k][j];
    end
    rrow[0] = r;
    for (int k = 0; k < PATH; k++)
      for (int j = 0; j < NPT; j++) rsnap[0][k][j] = snap[k][j];
    for (int i = HIST-1; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = o;
  endtask

  task automatic cyc(bit v, logic [PCW-1:0] pc, bit t, bit te, string tag);
    int r, e, a;
    @(negedge clk);
    br_valid = v; br_pc = pc; br_taken = t; train_en = te;
    #2;
    r = int'(pc) & (ROWS-1);
    e = expect_sum(r);
    a = pred_sum;
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s (R3 sum): act=%0d exp=%0d", tag, a, e);
    end
    total++;
    if (pred_taken != (e >= 0)) begin
      bad++;
      $display("FAIL %s (R2 taken): act=%0d exp=%0d", tag, pred_taken, (e >= 0));
    end
    @(posedge clk);
    if (v) commit(r, t, te);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PCW-1:0] pcs [4];
    for (int r = 0; r < ROWS; r++) begin
      mb[r] = 0;
      for (int t = 0; t < PATH; t++) for (int j = 0; j < NPT; j++) mw[t][r][j] = 0;
    end
    for (int i = 0; i < HIST; i++) mh[i] = 0;
    for (int m = 0; m < PATH; m++) begin
      rrow[m] = 0;
      for (int k = 0; k < PATH; k++) for (int j = 0; j < NPT; j++) rsnap[m][k][j] = 0;
    end
    rst_n = 1'b0; br_valid = 1'b0; br_pc = '0; br_taken = 1'b0; train_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    cyc(1'b1, 32'h0000_0123, 1'b0, 1'b1, "R1 reset state");

    for (int i = 0; i < 45; i++)
      cyc(1'b1, 32'h0000_0040, (i % 3) != 2, 1'b1, "R5 R6 R7 repeated address");

    for (int i = 0; i < 10; i++)
      cyc(1'b0, $urandom, i[0], 1'b1, "R8 idle");

    for (int i = 0; i < 30; i++)
      cyc(1'b1, {26'($urandom), 6'($urandom_range(0, 7))}, 1'($urandom), 1'b0, "R9 frozen");

    pcs[0] = 32'h0000_0005; pcs[1] = 32'h0000_1005; pcs[2] = 32'h0000_7005; pcs[3] = 32'h0000_0009;
    for (int i = 0; i < 60; i++)
      cyc(1'b1, pcs[(i / 2) % 4], ((i * 7) % 5) < 2, 1'b1, "R4 R10 aliasing rows");

    for (int i = 0; i < 700; i++) begin
      bit v, t;
      logic [PCW-1:0] pc;
      v = ($urandom_range(0, 9) != 0);
      pc = {26'($urandom), 6'($urandom_range(0, 11))};
      t = 1'(mh[2] ^ mh[5] ^ int'(pc[0]));
      if ($urandom_range(0, 9) == 0) t = ~t;
      cyc(v, pc, t, 1'b1, "R6 R7 R11 random mix");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule